// File: doc/BRIEF.md
# Page-Bounded Streaming Read Engine

This block takes one logical read of a contiguous byte range and returns it as a single ordered stream of data words. The request is a starting byte address and a byte length, and it is taken on a valid/ready handshake. The engine cuts the range into memory bursts and issues them on a simplified AXI4 read address channel. No burst crosses a 4 KB page and no burst is longer than a configured beat cap. Up to `N_SLOTS` bursts can be outstanding at once, and each one carries its own ID.

Beats come back on the read data channel, possibly with bursts interleaved out of order. Each beat is written into an on-chip buffer region that is tied to its burst's slot. The consumer side always drains the oldest slot first, so words leave in ascending address order regardless of the order in which memory answered. A busy output marks the active transaction. The request side stays closed until the last word has been taken.

The control is a three-state machine:
- `ST_IDLE` waits for a request. A request of non-zero length moves it to `ST_ISSUE`. A zero-length request is absorbed and it stays in `ST_IDLE`.
- `ST_ISSUE` places bursts while buffer slots are free. It moves to `ST_DRAIN` when the final burst is accepted.
- `ST_DRAIN` waits for the stream to empty. It returns to `ST_IDLE` in the cycle in which the consumer takes the final word.

Top module: `burst_read_engine`

## Requirements
- R1: After reset, `busy`, `ar_valid` and `out_valid` are 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only while no transaction is active. A request is taken when `req_valid` and `req_ready` are both 1, and `busy` is 1 from the next cycle with `req_ready` 0. A request whose length is 0 bytes issues no burst, produces no word, and leaves `busy` at 0 and `req_ready` at 1.
- R3: The burst addresses form a contiguous, ascending series that starts at `req_addr`. Each burst has `ar_len` + 1 beats, where the beat count is the least of three values: the words left before the next 4096-byte boundary, the words left in the request, and `MAX_BEATS`. No burst crosses a 4096-byte boundary. While `ar_valid` is 1 and not accepted, `ar_addr`, `ar_len` and `ar_id` hold their values.
- R4: IDs are handed out as 0, 1, …, `N_SLOTS`-1 and then wrap, in issue order. The count continues across transactions from its reset value of 0. No ID is issued again while an earlier burst under that ID still has beats to return.
- R5: `out_data` delivers the words of the requested range in ascending address order. This holds even when the bursts return in a different order from the one in which they were issued.
- R6: A word leaves only in a cycle where `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values.
- R7: `r_ready` is always 1, and every returned beat is kept.
- R8: `busy` falls, and `req_ready` rises, in the cycle right after the final word of the transaction is taken.
- R9: A burst is placed only when the next slot in ring order has been fully drained. If the consumer stalls, at most `N_SLOTS` bursts are issued, and after that `ar_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can take a request |
| req_addr | input | ADDR_W | Starting byte address, word aligned |
| req_len | input | LEN_W | Length in bytes, a whole number of words |
| busy | output | 1 | Transaction active |
| ar_valid | output | 1 | Burst address valid |
| ar_ready | input | 1 | Memory takes the burst address |
| ar_id | output | log2(N_SLOTS) | Burst ID |
| ar_addr | output | ADDR_W | Burst start byte address |
| ar_len | output | 8 | Beats in burst minus one |
| r_valid | input | 1 | Read beat valid |
| r_ready | output | 1 | Engine takes read beats |
| r_id | input | log2(N_SLOTS) | ID of the returning beat |
| r_data | input | 8*DATA_BYTES | Read beat data |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 8*DATA_BYTES | Output word |

## Verification
The bench's memory model can answer newest-first, so the reorder path is exercised. A design that drained from the slot being written, rather than from the oldest one, would emit words out of address order. Requests that start a few words below a 4 KB page boundary check the burst cut: an engine that capped only by length would issue a burst that straddles the page. A long consumer stall checks that issue stops after `N_SLOTS` bursts, since a design that ignored slot occupancy would overwrite buffered data or reuse a live ID. Zero-length requests, and the exact cycle in which `busy` falls, catch an engine that hangs in a non-idle state or reopens the request side one cycle early or late.

// File: rtl/rdeng_pkg.sv
package rdeng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } eng_state_e;

    function automatic int unsigned min3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a < b) ? a : b;
        return (m < c) ? m : c;
    endfunction

endpackage

// File: rtl/rdeng_burst_gen.sv
module rdeng_burst_gen
    import rdeng_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int DATA_BYTES = 4,
    parameter int PAGE_BYTES = 4096,
    parameter int MAX_BEATS  = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               load,
    input  logic [ADDR_W-1:0]                  load_addr,
    input  logic [LEN_W-1:0]                   load_len,
    input  logic                               step,
    output logic [ADDR_W-1:0]                  cur_addr,
    output logic [$clog2(MAX_BEATS):0]         beats,
    output logic                               last
);

    localparam int DB_LG      = $clog2(DATA_BYTES);
    localparam int PAGE_LG    = $clog2(PAGE_BYTES);
    localparam int PAGE_WORDS = PAGE_BYTES / DATA_BYTES;
    localparam int WORDS_W    = LEN_W - DB_LG + 1;
    localparam int CNT_W      = $clog2(MAX_BEATS) + 1;

    logic [ADDR_W-1:0]  addr_q;
    logic [WORDS_W-1:0] rem_q;
    int unsigned        room_words;
    int unsigned        rem_words;
    int unsigned        burst_words;

    // Words available before the page edge, the request end and the cap.
    always_comb begin
        room_words  = PAGE_WORDS - int'(addr_q[PAGE_LG-1:DB_LG]);
        rem_words   = int'(rem_q);
        burst_words = min3(room_words, rem_words, MAX_BEATS);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            rem_q  <= WORDS_W'(load_len >> DB_LG);
        end else if (step) begin
            addr_q <= addr_q + (ADDR_W'(burst_words) << DB_LG);
            rem_q  <= rem_q - WORDS_W'(burst_words);
        end
    end

    assign cur_addr = addr_q;
    assign beats    = CNT_W'(burst_words);
    assign last     = (rem_words == burst_words);

endmodule

// File: rtl/rdeng_slot_buf.sv
module rdeng_slot_buf #(
    parameter int N_SLOTS   = 4,
    parameter int MAX_BEATS = 16,
    parameter int DATA_W    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc,
    input  logic [$clog2(MAX_BEATS):0]   alloc_beats,
    output logic                         alloc_ok,
    output logic [$clog2(N_SLOTS)-1:0]   alloc_id,
    input  logic                         wr_valid,
    input  logic [$clog2(N_SLOTS)-1:0]   wr_id,
    input  logic [DATA_W-1:0]            wr_data,
    output logic                         rd_valid,
    input  logic                         rd_ready,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         drain_done
);

    localparam int SLOT_W = $clog2(N_SLOTS);
    localparam int BEAT_W = $clog2(MAX_BEATS);
    localparam int CNT_W  = BEAT_W + 1;
    localparam int DEPTH  = N_SLOTS * MAX_BEATS;

    logic [DATA_W-1:0] mem_q [DEPTH];

    logic [N_SLOTS-1:0] slot_busy;
    logic [CNT_W-1:0]   beats_a [N_SLOTS];
    logic [CNT_W-1:0]   wcnt_a  [N_SLOTS];
    logic [CNT_W-1:0]   rcnt_a  [N_SLOTS];

    logic [SLOT_W-1:0]  iss_ptr_q;
    logic [SLOT_W-1:0]  drn_ptr_q;
    logic               rd_fire;
    logic               slot_free;
    logic [CNT_W-1:0]   head_rcnt;
    logic [CNT_W-1:0]   wr_cnt;

    assign rd_fire   = rd_valid && rd_ready;
    assign head_rcnt = rcnt_a[drn_ptr_q];
    assign slot_free = rd_fire && ((head_rcnt + CNT_W'(1)) == beats_a[drn_ptr_q]);

    // One set of counters per slot.
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        logic             busy_q;
        logic [CNT_W-1:0] beats_q;
        logic [CNT_W-1:0] wcnt_q;
        logic [CNT_W-1:0] rcnt_q;
        logic             is_alloc;
        logic             is_wr;
        logic             is_rd;

        assign is_alloc = alloc && (iss_ptr_q == SLOT_W'(g));
        assign is_wr    = wr_valid && (wr_id == SLOT_W'(g));
        assign is_rd    = rd_fire && (drn_ptr_q == SLOT_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_q  <= 1'b0;
                beats_q <= '0;
                wcnt_q  <= '0;
                rcnt_q  <= '0;
            end else if (is_alloc) begin
                busy_q  <= 1'b1;
                beats_q <= alloc_beats;
                wcnt_q  <= '0;
                rcnt_q  <= '0;
            end else begin
                if (is_wr) begin
                    wcnt_q <= wcnt_q + CNT_W'(1);
                end
                if (is_rd) begin
                    rcnt_q <= rcnt_q + CNT_W'(1);
                    if ((rcnt_q + CNT_W'(1)) == beats_q) begin
                        busy_q <= 1'b0;
                    end
                end
            end
        end

        assign slot_busy[g] = busy_q;
        assign beats_a[g]   = beats_q;
        assign wcnt_a[g]    = wcnt_q;
        assign rcnt_a[g]    = rcnt_q;
    end

    assign wr_cnt = wcnt_a[wr_id];

    always_ff @(posedge clk) begin
        if (wr_valid) begin
            mem_q[{wr_id, wr_cnt[BEAT_W-1:0]}] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_ptr_q <= '0;
            drn_ptr_q <= '0;
        end else begin
            if (alloc) begin
                iss_ptr_q <= iss_ptr_q + SLOT_W'(1);
            end
            if (slot_free) begin
                drn_ptr_q <= drn_ptr_q + SLOT_W'(1);
            end
        end
    end

    assign alloc_ok   = !slot_busy[iss_ptr_q];
    assign alloc_id   = iss_ptr_q;
    assign rd_valid   = slot_busy[drn_ptr_q] && (head_rcnt != wcnt_a[drn_ptr_q]);
    assign rd_data    = mem_q[{drn_ptr_q, head_rcnt[BEAT_W-1:0]}];
    assign drain_done = slot_free && ($countones(slot_busy) == 1);

endmodule

// File: rtl/burst_read_engine.sv
module burst_read_engine
    import rdeng_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int DATA_BYTES = 4,
    parameter int N_SLOTS    = 4,
    parameter int MAX_BEATS  = 16,
    parameter int PAGE_BYTES = 4096
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [LEN_W-1:0]              req_len,
    output logic                          busy,
    output logic                          ar_valid,
    input  logic                          ar_ready,
    output logic [$clog2(N_SLOTS)-1:0]    ar_id,
    output logic [ADDR_W-1:0]             ar_addr,
    output logic [7:0]                    ar_len,
    input  logic                          r_valid,
    output logic                          r_ready,
    input  logic [$clog2(N_SLOTS)-1:0]    r_id,
    input  logic [DATA_BYTES*8-1:0]       r_data,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [DATA_BYTES*8-1:0]       out_data
);

    localparam int DATA_W = DATA_BYTES * 8;
    localparam int DB_LG  = $clog2(DATA_BYTES);
    localparam int CNT_W  = $clog2(MAX_BEATS) + 1;

    eng_state_e       state_q, state_d;
    logic             accept;
    logic             zero_len;
    logic             ar_fire;
    logic             slot_ok;
    logic             drain_done;
    logic             gen_last;
    logic [CNT_W-1:0] gen_beats;

    assign accept   = req_valid && req_ready;
    assign zero_len = ((req_len >> DB_LG) == '0);
    assign ar_fire  = ar_valid && ar_ready;

    rdeng_burst_gen #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .DATA_BYTES (DATA_BYTES),
        .PAGE_BYTES (PAGE_BYTES),
        .MAX_BEATS  (MAX_BEATS)
    ) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_addr (req_addr),
        .load_len  (req_len),
        .step      (ar_fire),
        .cur_addr  (ar_addr),
        .beats     (gen_beats),
        .last      (gen_last)
    );

    rdeng_slot_buf #(
        .N_SLOTS   (N_SLOTS),
        .MAX_BEATS (MAX_BEATS),
        .DATA_W    (DATA_W)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc       (ar_fire),
        .alloc_beats (gen_beats),
        .alloc_ok    (slot_ok),
        .alloc_id    (ar_id),
        .wr_valid    (r_valid),
        .wr_id       (r_id),
        .wr_data     (r_data),
        .rd_valid    (out_valid),
        .rd_ready    (out_ready),
        .rd_data     (out_data),
        .drain_done  (drain_done)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !zero_len) begin
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (ar_fire && gen_last) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (drain_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        req_ready = 1'b0;
        busy      = 1'b1;
        ar_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                busy      = 1'b0;
            end
            ST_ISSUE: begin
                ar_valid = slot_ok;
            end
            ST_DRAIN: begin
                ar_valid = 1'b0;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    assign ar_len  = 8'(gen_beats - CNT_W'(1));
    assign r_ready = 1'b1;

endmodule

// File: rtl/rdeng_checker.sv
module rdeng_checker #(
    parameter int ID_W       = 2,
    parameter int N_SLOTS    = 4,
    parameter int MAX_BEATS  = 16,
    parameter int DATA_W     = 32,
    parameter int PAGE_LG    = 12,
    parameter int DATA_BYTES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               ar_valid,
    input logic               ar_ready,
    input logic [ID_W-1:0]    ar_id,
    input logic [PAGE_LG-1:0] ar_page_off,
    input logic [7:0]         ar_len,
    input logic               r_valid,
    input logic               r_ready,
    input logic [ID_W-1:0]    r_id,
    input logic               out_valid,
    input logic               out_ready,
    input logic [DATA_W-1:0]  out_data
);

    // Beats still owed per ID, observed from the two channels.
    logic [8:0] owed_q [N_SLOTS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SLOTS; i++) begin
                owed_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N_SLOTS; i++) begin
                if (ar_valid && ar_ready && (ar_id == ID_W'(i))) begin
                    owed_q[i] <= 9'(ar_len) + 9'd1;
                end else if (r_valid && r_ready && (r_id == ID_W'(i)) && (owed_q[i] != '0)) begin
                    owed_q[i] <= owed_q[i] - 9'd1;
                end
            end
        end
    end

    a_r3_page_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> ((int'(ar_page_off) + (int'(ar_len) + 1) * DATA_BYTES) <= (1 << PAGE_LG)));

    a_r3_beat_cap: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> (int'(ar_len) < MAX_BEATS));

    a_r3_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_page_off) && $stable(ar_len) && $stable(ar_id)));

    a_r4_id_unique: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> (owed_q[ar_id] == '0));

    a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r8_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(out_valid && out_ready));

endmodule

bind burst_read_engine rdeng_checker #(
    .ID_W       ($clog2(N_SLOTS)),
    .N_SLOTS    (N_SLOTS),
    .MAX_BEATS  (MAX_BEATS),
    .DATA_W     (DATA_BYTES * 8),
    .PAGE_LG    ($clog2(PAGE_BYTES)),
    .DATA_BYTES (DATA_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .ar_valid    (ar_valid),
    .ar_ready    (ar_ready),
    .ar_id       (ar_id),
    .ar_page_off (ar_addr[$clog2(PAGE_BYTES)-1:0]),
    .ar_len      (ar_len),
    .r_valid     (r_valid),
    .r_ready     (r_ready),
    .r_id        (r_id),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data)
);

// File: tb/burst_read_engine_tb.sv
module burst_read_engine_tb;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int DB     = 4;
    localparam int NS     = 4;
    localparam int MB     = 16;
    localparam int PAGE   = 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              busy;
    logic              ar_valid;
    logic              ar_ready = 1'b0;
    logic [1:0]        ar_id;
    logic [ADDR_W-1:0] ar_addr;
    logic [7:0]        ar_len;
    logic              r_valid = 1'b0;
    logic              r_ready;
    logic [1:0]        r_id = '0;
    logic [31:0]       r_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [31:0]       out_data;

    burst_read_engine #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_BYTES(DB),
        .N_SLOTS(NS), .MAX_BEATS(MB), .PAGE_BYTES(PAGE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .busy(busy),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr), .ar_len(ar_len),
        .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_err    = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a ^ 32'hC0DE_0000;
    endfunction

    // Agent configuration and state.
    bit          agent_on = 0;
    bit          go = 0;
    bit          xfer_done = 0;
    bit          busy_chk = 0;
    bit          first_after = 0;
    string       end_tag = "R8";
    int          x_addr, x_len;
    int          rmode, omode, amode;
    int          stall_cnt = 0;
    int unsigned cyc = 0;
    logic [31:0] exp_addr, exp_out;
    int          exp_rem = 0;
    int          words_left = 0;
    int          exp_id = 0;
    int          nb = 0;
    int          cur = -1;
    int          beat = 0;
    logic [31:0] pb_addr [64];
    int          pb_len  [64];
    logic [1:0]  pb_id   [64];
    bit          pb_done [64];

    always @(negedge clk) begin
        if (agent_on) begin
            bit ordrv;
            bit ardrv;
            int pend;
            int room, eb;
            cyc++;

            if (busy_chk) begin
                chk(busy == 1'b0 && req_ready == 1'b1, end_tag, {30'd0, busy, req_ready}, 32'h1);
                busy_chk  = 0;
                xfer_done = 1;
            end

            // Request side (R2)
            req_valid = 1'b0;
            if (go) begin
                chk(req_ready == 1'b1, "R2 idle ready", {31'd0, req_ready}, 32'h1);
                req_valid  = 1'b1;
                req_addr   = x_addr;
                req_len    = LEN_W'(x_len);
                go         = 0;
                exp_addr   = x_addr;
                exp_out    = x_addr;
                exp_rem    = x_len / DB;
                words_left = x_len / DB;
                nb         = 0;
                cur        = -1;
                if (words_left == 0) begin
                    busy_chk = 1;
                    end_tag  = "R2 zero length";
                end else begin
                    first_after = 1;
                    end_tag     = "R8 busy fall";
                end
            end else if (first_after) begin
                chk(busy == 1'b1 && req_ready == 1'b0, "R2 busy after accept",
                    {30'd0, busy, req_ready}, 32'h2);
                first_after = 0;
            end

            // Read data returns (R5, R7); bursts recorded last cycle only.
            r_valid = 1'b0;
            if (cur < 0) begin
                pend = 0;
                for (int i = 0; i < nb; i++) if (!pb_done[i]) pend++;
                if (pend > 0 && (rmode == 0 || pend >= 2 || !ar_valid)) begin
                    if (rmode == 0) begin
                        for (int i = nb - 1; i >= 0; i--) if (!pb_done[i]) cur = i;
                    end else begin
                        for (int i = 0; i < nb; i++) if (!pb_done[i]) cur = i;
                    end
                    beat = 0;
                end
            end
            if (cur >= 0) begin
                chk(r_ready == 1'b1, "R7 r_ready", {31'd0, r_ready}, 32'h1);
                r_valid = 1'b1;
                r_id    = pb_id[cur];
                r_data  = mem_word(pb_addr[cur] + 32'(beat * DB));
                beat++;
                if (beat == pb_len[cur]) begin
                    pb_done[cur] = 1;
                    cur = -1;
                end
            end

            // Burst address channel (R3, R4)
            ardrv = (amode == 0) || (cyc % 3 != 0);
            if (ar_valid && ardrv) begin
                room = (PAGE - int'(exp_addr % PAGE)) / DB;
                eb   = room;
                if (exp_rem < eb) eb = exp_rem;
                if (MB < eb) eb = MB;
                chk(exp_rem > 0, "R3 no extra burst", 32'(exp_rem), 32'h1);
                chk(ar_addr == exp_addr, "R3 burst address", ar_addr, exp_addr);
                chk(int'(ar_len) == eb - 1, "R3 burst length", 32'(ar_len), 32'(eb - 1));
                chk(int'(ar_id) == exp_id, "R4 burst id", 32'(ar_id), 32'(exp_id));
                pb_addr[nb] = ar_addr;
                pb_len[nb]  = int'(ar_len) + 1;
                pb_id[nb]   = ar_id;
                pb_done[nb] = 0;
                nb++;
                exp_addr = exp_addr + 32'(eb * DB);
                exp_rem  = exp_rem - eb;
                exp_id   = (exp_id + 1) % NS;
            end
            ar_ready = ardrv;

            // Consumer (R5, R6, R9)
            if (omode == 0) ordrv = 1;
            else if (omode == 1) ordrv = cyc[0];
            else begin
                ordrv = (stall_cnt == 0);
                if (stall_cnt == 1) begin
                    chk(nb == NS && ar_valid == 1'b0, "R9 issue stops at slot limit",
                        {nb[30:0], ar_valid}, {31'(NS), 1'b0});
                end
                if (stall_cnt > 0) stall_cnt--;
            end
            if (out_valid && ordrv) begin
                chk(words_left > 0, "R5 no surplus word", 32'(words_left), 32'h1);
                chk(out_data == mem_word(exp_out), "R5 R6 word order", out_data, mem_word(exp_out));
                exp_out = exp_out + DB;
                words_left--;
                if (words_left == 0) busy_chk = 1;
            end
            out_ready = ordrv;
        end
    end

    task automatic run_xfer(input int addr, input int len, input int rm, input int om,
                            input int am, input int stall, input int exp_bursts, input string tag);
        @(posedge clk);
        x_addr    = addr;
        x_len     = len;
        rmode     = rm;
        omode     = om;
        amode     = am;
        stall_cnt = stall;
        xfer_done = 0;
        go        = 1;
        wait (xfer_done);
        chk(nb == exp_bursts, tag, 32'(nb), 32'(exp_bursts));
        chk(exp_rem == 0, "R3 range covered", 32'(exp_rem), 32'h0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy", {31'd0, busy}, 32'h0);
        chk(req_ready == 1'b1, "R1 req_ready", {31'd0, req_ready}, 32'h1);
        chk(ar_valid == 1'b0, "R1 ar_valid", {31'd0, ar_valid}, 32'h0);
        chk(out_valid == 1'b0, "R1 out_valid", {31'd0, out_valid}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && busy == 1'b0, "R1 idle after reset", {30'd0, busy, req_ready}, 32'h1);
        agent_on = 1;
    endtask

    task automatic t_zero_len;
        run_xfer(32'h0000_0800, 0, 0, 0, 0, 0, 0, "R2 zero length bursts");
        repeat (4) begin
            @(negedge clk);
            chk(ar_valid == 1'b0 && out_valid == 1'b0 && busy == 1'b0, "R2 zero length quiet",
                {29'd0, ar_valid, out_valid, busy}, 32'h0);
        end
    endtask

    initial begin
        t_reset();
        run_xfer(32'h0000_0100,  16, 0, 0, 0, 0,  1, "R3 single burst count");
        run_xfer(32'h0000_0FF0,  64, 0, 0, 0, 0,  2, "R3 page cut count");
        run_xfer(32'h0000_2000, 512, 1, 0, 0, 0,  8, "R5 reorder burst count");
        run_xfer(32'h0000_3000, 512, 0, 2, 0, 30, 8, "R9 stalled burst count");
        run_xfer(32'h0000_1FE8, 200, 1, 1, 1, 0,  4, "R6 throttled burst count");
        t_zero_len();
        run_xfer(32'h0000_4FC0, 128, 1, 0, 1, 0,  2, "R4 id wrap burst count");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule